// File: doc/BRIEF.md
# Floating-Point Status Register Update Unit

This block owns the floating-point status word of a scalar FPU and rewrites it when each floating-point operation retires. The arithmetic datapath presents five raw IEEE exception flags with a valid strobe. For a comparison it also presents a relation code, the number of the condition field to write, whether the compare is signaling or quiet, whether either operand was a quiet or a signaling NaN, and whether the compare used the widest format. The unit records the current exceptions and checks them against the trap enables. It then either requests an FP-exception trap or folds the exceptions into the accrued field. For a compare it stores the relation in the selected condition field.

Software can load the register in a 32-bit or a 64-bit form. Each form changes only the bits of its own load mask. The rounding-direction field is decoded continuously into a one-hot select that goes back to the datapath. All updates take effect on the clock edge that samples the strobe. The trap request is high for exactly the one cycle after that edge.

Top module: `fsr_update_unit`

## Requirements
- R1: While reset is low, and on the first cycle after it, the register reads 0, trap_req and trap_type are 0, and rnd_sel is 4'b0001.
- R2: Every accepted operation replaces the current-exception field, bits [4:0], with its raw flags. The bits are [4]=invalid, [3]=overflow, [2]=underflow, [1]=divide-by-zero, [0]=inexact.
- R3: When the new current exceptions AND the trap enables, bits [27:23] in the same order, give a nonzero value, trap_req is high for one cycle only. That cycle follows the edge that took the operation. trap_type reads 8'h21 in that cycle and 0 otherwise, and the trap-type field [16:14] becomes 3'd1.
- R4: A trapping operation changes neither the accrued field nor any condition field.
- R5: A non-trapping operation ORs its current exceptions into the accrued field, bits [9:5], in the same bit order.
- R6: An operation with all flags clear sets bits [4:0] to zero and leaves bits [9:5] unchanged.
- R7: A non-trapping compare writes its relation code {hi,lo} into one condition field: 00 for equal, 01 for less, 10 for greater, 11 for unordered. Select 0 writes [11:10], select 1 writes [33:32], select 2 writes [35:34] and select 3 writes [37:36]. The other fields stay unchanged.
- R8: A signaling compare raises invalid when either operand is a NaN of either kind. A quiet compare raises invalid only for a signaling NaN.
- R9: A non-trapping wide-format compare that returns unordered also sets accrued invalid, bit 9, even when no invalid flag was raised.
- R10: rnd_sel decodes bits [31:30]: 00 gives 4'b0001 (nearest-even), 01 gives 4'b0010 (toward zero), 10 gives 4'b0100 (toward +infinity) and 11 gives 4'b1000 (toward -infinity).
- R11: A 32-bit load writes only the bits under mask 64'h0000_0000_CF80_0FFF. A 64-bit load writes only the bits under 64'h0000_003F_CF80_0FFF. All other bits keep their old value.
- R12: A load takes priority over an operation in the same cycle. That operation is then ignored and no trap is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An FP operation retires this cycle |
| op_flags | input | 5 | Raw IEEE flags {invalid, overflow, underflow, div0, inexact} |
| op_cmp | input | 1 | The retiring operation is a compare |
| cmp_code | input | 2 | Relation: 00 eq, 01 lt, 10 gt, 11 unordered |
| cmp_sel | input | 2 | Condition field to write (0..3) |
| cmp_signal | input | 1 | 1 for a signaling compare, 0 for quiet |
| cmp_qnan | input | 1 | An operand was a quiet NaN |
| cmp_snan | input | 1 | An operand was a signaling NaN |
| cmp_wide | input | 1 | Compare used the widest format |
| ld_valid | input | 1 | Software load of the register |
| ld_wide | input | 1 | 1 for a 64-bit load, 0 for a 32-bit load |
| ld_data | input | 64 | Load value |
| fsr | output | 64 | Status register |
| trap_req | output | 1 | One-cycle FP-exception trap request |
| trap_type | output | 8 | Trap type while trap_req is high, else 0 |
| rnd_sel | output | 4 | One-hot rounding mode for the datapath |

## Verification
The bench targets three faults. The first is a trap that still accumulates or still writes a condition code, which would leave a stale accrued or condition value behind a trap. The second is a quiet compare that treats a quiet NaN as invalid, which would set bit 4 where it must stay clear. The third is a wide unordered compare that forgets bit 9. The bench also aims loads at the mask boundaries. A 32-bit load carries ones in the upper word that must not land in the extra condition fields. A load paired with a flagged operation must show neither the operation's cexc nor a trap. Each condition-field select is written and checked against its neighbours, so a misplaced shift shows up as a corrupted adjacent pair.

// File: rtl/fsr_pkg.sv
// Package: bit positions and encodings of the FP status word.
// Assumes a 64-bit register; the positions are fixed because the
// trap/accrue decision and the datapath decode depend on them.
package fsr_pkg;
    localparam int FSR_W     = 64;
    localparam int EXC_W     = 5;
    localparam int CEXC_LSB  = 0;
    localparam int AEXC_LSB  = CEXC_LSB + EXC_W;
    localparam int TEM_LSB   = CEXC_LSB + 23;
    localparam int FTT_LSB   = 14;
    localparam int FTT_W     = 3;
    localparam int RD_LSB    = 30;
    localparam int RD_W      = 2;
    localparam int FCC_BASE  = 10;
    localparam int FCC_W     = 2;
    localparam int N_FCC     = 4;
    localparam int SEL_W     = $clog2(N_FCC);
    localparam int EXC_NV    = 4;
    localparam int TT_W      = 8;
    localparam int RND_N     = 1 << RD_W;

    localparam logic [FTT_W-1:0] FTT_IEEE  = 3'd1;
    localparam logic [FSR_W-1:0] LD32_MASK = 64'h0000_0000_CF80_0FFF;
    localparam logic [FSR_W-1:0] LD64_MASK = 64'h0000_003F_CF80_0FFF;

    typedef enum logic [FCC_W-1:0] {
        REL_EQ = 2'b00,
        REL_LT = 2'b01,
        REL_GT = 2'b10,
        REL_UN = 2'b11
    } rel_e;

    // Lowest bit of condition field k: field 0 at the base, the others
    // at added shifts of 22, 24 and 26 from the base.
    function automatic int fcc_lsb(input int k);
        return (k == 0) ? FCC_BASE : FCC_BASE + 20 + 2 * k;
    endfunction
endpackage

// File: rtl/fsr_exc_unit.sv
// Exception unit: forms the current-exception vector of the retiring
// operation (adding compare-generated invalid) and decides whether it
// hits an enabled trap. Purely combinational; assumes the flags are
// valid whenever the caller qualifies them with its strobe.
module fsr_exc_unit
    import fsr_pkg::*;
(
    input  logic [EXC_W-1:0] raw_flags,
    input  logic             is_cmp,
    input  logic             cmp_signal,
    input  logic             cmp_qnan,
    input  logic             cmp_snan,
    input  logic [EXC_W-1:0] trap_en,
    output logic [EXC_W-1:0] cexc,
    output logic             trap_hit
);
    logic cmp_invalid;

    // Compare invalid: any NaN when signaling, only signaling NaNs when quiet.
    always_comb begin
        cmp_invalid = is_cmp && (cmp_snan || (cmp_signal && cmp_qnan));
    end

    // Current exceptions and the enabled-trap test.
    always_comb begin
        cexc = raw_flags;
        cexc[EXC_NV] = raw_flags[EXC_NV] | cmp_invalid;
        trap_hit = |(cexc & trap_en);
    end

    // A compare that saw a signaling NaN must always report invalid (R8).
    always_comb begin
        if (is_cmp && cmp_snan) begin
            p_snan_invalid_r8: assert (cexc[EXC_NV] == 1'b1)
                else $error("snan compare without invalid");
        end
    end
endmodule

// File: rtl/fsr_fcc_unit.sv
// Condition-field unit: takes the four condition fields and writes the
// relation code into the selected one when enabled. One generate slice
// per field; assumes sel is in range 0..N_FCC-1.
module fsr_fcc_unit
    import fsr_pkg::*;
(
    input  logic [N_FCC*FCC_W-1:0] fcc_in,
    input  logic                   wr_en,
    input  logic [SEL_W-1:0]       sel,
    input  logic [FCC_W-1:0]       code,
    output logic [N_FCC*FCC_W-1:0] fcc_out
);
    for (genvar k = 0; k < N_FCC; k++) begin : g_field
        // Replace this field only when it is the selected one.
        always_comb begin
            if (wr_en && (sel == SEL_W'(k)))
                fcc_out[k*FCC_W +: FCC_W] = code;
            else
                fcc_out[k*FCC_W +: FCC_W] = fcc_in[k*FCC_W +: FCC_W];
        end
    end
endmodule

// File: rtl/fsr_rnd_decode.sv
// Rounding decode: turns the 2-bit rounding-direction field into a
// one-hot select {-inf, +inf, zero, nearest}. An undefined value falls
// back to toward-zero.
module fsr_rnd_decode
    import fsr_pkg::*;
(
    input  logic [RD_W-1:0]  rd,
    output logic [RND_N-1:0] rnd_sel
);
    // Field value to one-hot mode.
    always_comb begin
        case (rd)
            2'b00:   rnd_sel = 4'b0001;
            2'b01:   rnd_sel = 4'b0010;
            2'b10:   rnd_sel = 4'b0100;
            2'b11:   rnd_sel = 4'b1000;
            default: rnd_sel = 4'b0010;
        endcase
    end
endmodule

// File: rtl/fsr_update_unit.sv
// Top: holds the FP status register. On an operation strobe it records
// the current exceptions, then either raises a one-cycle trap (setting
// the trap-type field and nothing else) or accumulates and writes the
// compare result. Software loads replace masked bits and win over an
// operation in the same cycle. Synchronous active-low reset.
module fsr_update_unit
    import fsr_pkg::*;
#(
    parameter logic [TT_W-1:0] TRAP_CODE = 8'h21
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_valid,
    input  logic [EXC_W-1:0]   op_flags,
    input  logic               op_cmp,
    input  logic [FCC_W-1:0]   cmp_code,
    input  logic [SEL_W-1:0]   cmp_sel,
    input  logic               cmp_signal,
    input  logic               cmp_qnan,
    input  logic               cmp_snan,
    input  logic               cmp_wide,
    input  logic               ld_valid,
    input  logic               ld_wide,
    input  logic [FSR_W-1:0]   ld_data,
    output logic [FSR_W-1:0]   fsr,
    output logic               trap_req,
    output logic [TT_W-1:0]    trap_type,
    output logic [RND_N-1:0]   rnd_sel
);
    logic [FSR_W-1:0]       fsr_q, fsr_n, ld_mask;
    logic [EXC_W-1:0]       cexc;
    logic                   trap_hit, op_take, fcc_wr, wide_unord;
    logic                   trap_q, trap_n;
    logic [N_FCC*FCC_W-1:0] fcc_cur, fcc_new;

    fsr_exc_unit u_exc (
        .raw_flags (op_flags),
        .is_cmp    (op_cmp),
        .cmp_signal(cmp_signal),
        .cmp_qnan  (cmp_qnan),
        .cmp_snan  (cmp_snan),
        .trap_en   (fsr_q[TEM_LSB +: EXC_W]),
        .cexc      (cexc),
        .trap_hit  (trap_hit)
    );

    // Gather the four condition fields from their scattered positions.
    for (genvar k = 0; k < N_FCC; k++) begin : g_gather
        assign fcc_cur[k*FCC_W +: FCC_W] = fsr_q[fcc_lsb(k) +: FCC_W];
    end

    // Strobe qualification: loads win, traps suppress result writes.
    always_comb begin
        op_take    = op_valid && !ld_valid;
        fcc_wr     = op_take && op_cmp && !trap_hit;
        wide_unord = op_cmp && cmp_wide && (cmp_code == REL_UN);
        ld_mask    = ld_wide ? LD64_MASK : LD32_MASK;
    end

    fsr_fcc_unit u_fcc (
        .fcc_in (fcc_cur),
        .wr_en  (fcc_wr),
        .sel    (cmp_sel),
        .code   (cmp_code),
        .fcc_out(fcc_new)
    );

    fsr_rnd_decode u_rnd (
        .rd     (fsr_q[RD_LSB +: RD_W]),
        .rnd_sel(rnd_sel)
    );

    // Next register value and trap pulse.
    always_comb begin
        fsr_n  = fsr_q;
        trap_n = 1'b0;
        if (ld_valid) begin
            fsr_n = (ld_data & ld_mask) | (fsr_q & ~ld_mask);
        end else if (op_valid) begin
            fsr_n[CEXC_LSB +: EXC_W] = cexc;
            if (trap_hit) begin
                fsr_n[FTT_LSB +: FTT_W] = FTT_IEEE;
                trap_n = 1'b1;
            end else begin
                fsr_n[AEXC_LSB +: EXC_W] = fsr_q[AEXC_LSB +: EXC_W] | cexc;
                if (wide_unord)
                    fsr_n[AEXC_LSB + EXC_NV] = 1'b1;
                for (int k = 0; k < N_FCC; k++)
                    fsr_n[fcc_lsb(k) +: FCC_W] = fcc_new[k*FCC_W +: FCC_W];
            end
        end
    end

    // State registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsr_q  <= '0;
            trap_q <= 1'b0;
        end else begin
            fsr_q  <= fsr_n;
            trap_q <= trap_n;
        end
    end

    assign fsr       = fsr_q;
    assign trap_req  = trap_q;
    assign trap_type = trap_q ? TRAP_CODE : '0;

    // A trap leaves the IEEE trap-type code in the register (R3).
    p_trap_ftt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (fsr[FTT_LSB +: FTT_W] == FTT_IEEE));

    // A trap pulse only follows an accepted operation (R3, R12).
    p_trap_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> $past(op_valid && !ld_valid));

    // A trap leaves the accrued field untouched (R4).
    p_trap_keeps_aexc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (fsr[AEXC_LSB +: EXC_W] == $past(fsr[AEXC_LSB +: EXC_W])));

    // Accrued bits never drop on an operation (R5).
    p_aexc_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !ld_valid) |=> ((fsr[AEXC_LSB +: EXC_W] & $past(fsr[AEXC_LSB +: EXC_W]))
                                     == $past(fsr[AEXC_LSB +: EXC_W])));

    // At most one condition field changes per cycle without a load (R7).
    p_one_fcc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |-> ($countones({fcc_new[1:0] != fcc_cur[1:0], fcc_new[3:2] != fcc_cur[3:2],
                                   fcc_new[5:4] != fcc_cur[5:4], fcc_new[7:6] != fcc_cur[7:6]}) <= 1));

    // The rounding select is always exactly one mode (R10).
    p_rnd_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rnd_sel) == 1);

    // A load never produces a trap (R12).
    p_load_no_trap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> !trap_req);
endmodule

// File: tb/sim_fsr_update_unit.sv
// Bench: behavioural reference model of the status word, compared with
// every output after every clock edge.
module sim_fsr_update_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid, op_cmp, cmp_signal, cmp_qnan, cmp_snan, cmp_wide;
    logic [4:0]  op_flags;
    logic [1:0]  cmp_code, cmp_sel;
    logic        ld_valid, ld_wide;
    logic [63:0] ld_data;
    logic [63:0] fsr;
    logic        trap_req;
    logic [7:0]  trap_type;
    logic [3:0]  rnd_sel;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [63:0] m_fsr;
    bit          m_trap;

    always #2 clk = ~clk;

    fsr_update_unit u0 (.*);

    task automatic clear_inputs();
        op_valid = 0; op_flags = 0; op_cmp = 0; cmp_code = 0; cmp_sel = 0;
        cmp_signal = 0; cmp_qnan = 0; cmp_snan = 0; cmp_wide = 0;
        ld_valid = 0; ld_wide = 0; ld_data = 0;
    endtask

    // Reference update for one edge, from the requirement text.
    task automatic model_edge();
        logic [63:0] mask;
        logic [4:0]  cx;
        int          pos;
        if (!rst_n) begin
            m_fsr = 0; m_trap = 0;
        end else if (ld_valid) begin
            mask = ld_wide ? 64'h0000_003F_CF80_0FFF : 64'h0000_0000_CF80_0FFF;
            m_fsr = (ld_data & mask) | (m_fsr & ~mask);
            m_trap = 0;
        end else if (op_valid) begin
            cx = op_flags;
            if (op_cmp && (cmp_snan || (cmp_signal && cmp_qnan))) cx[4] = 1'b1;
            m_fsr[4:0] = cx;
            if ((cx & m_fsr[27:23]) != 0) begin
                m_fsr[16:14] = 3'd1;
                m_trap = 1;
            end else begin
                m_trap = 0;
                m_fsr[9:5] = m_fsr[9:5] | cx;
                if (op_cmp) begin
                    case (cmp_sel)
                        2'd0: pos = 10;
                        2'd1: pos = 32;
                        2'd2: pos = 34;
                        default: pos = 36;
                    endcase
                    m_fsr[pos +: 2] = cmp_code;
                    if (cmp_wide && cmp_code == 2'b11) m_fsr[9] = 1'b1;
                end
            end
        end else begin
            m_trap = 0;
        end
    endtask

    // One clock: model the edge, then compare away from it.
    task automatic step(input string tag);
        logic [3:0] exp_rnd;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        case (m_fsr[31:30])
            2'b00: exp_rnd = 4'b0001;
            2'b01: exp_rnd = 4'b0010;
            2'b10: exp_rnd = 4'b0100;
            default: exp_rnd = 4'b1000;
        endcase
        checks++;
        if (fsr !== m_fsr || trap_req !== m_trap || rnd_sel !== exp_rnd ||
            trap_type !== (m_trap ? 8'h21 : 8'h00)) begin
            fails++;
            $display("FAIL %s: fsr=%h trap=%b tt=%h rnd=%b expected fsr=%h trap=%b tt=%h rnd=%b",
                     tag, fsr, trap_req, trap_type, rnd_sel, m_fsr, m_trap,
                     m_trap ? 8'h21 : 8'h00, exp_rnd);
        end
        clear_inputs();
    endtask

    task automatic op(input logic [4:0] f, input string tag);
        op_valid = 1; op_flags = f;
        step(tag);
    endtask

    task automatic cmp(input logic [1:0] sel, input logic [1:0] code, input bit sig,
                       input bit qn, input bit sn, input bit wide, input logic [4:0] f,
                       input string tag);
        op_valid = 1; op_cmp = 1; cmp_sel = sel; cmp_code = code; cmp_signal = sig;
        cmp_qnan = qn; cmp_snan = sn; cmp_wide = wide; op_flags = f;
        step(tag);
    endtask

    task automatic load(input logic [63:0] d, input bit wide, input string tag);
        ld_valid = 1; ld_wide = wide; ld_data = d;
        step(tag);
    endtask

    initial begin
        clear_inputs();
        rst_n = 0;
        @(negedge clk);
        step("R1");
        step("R1");
        rst_n = 1;
        step("R1");                                   // first cycle out of reset
        op(5'b00101, "R2");                           // cexc=00101, aexc=00101
        op(5'b00000, "R6");                           // cexc cleared, aexc kept
        op(5'b01000, "R5");                           // aexc grows to 01101
        load(64'hFFFF_FFFF_8080_0C00, 0, "R11");      // 32-bit: upper ones ignored
        step("R10");                                  // +inf select held
        op(5'b00001, "R3");                           // inexact enabled: trap
        step("R3");                                   // pulse is one cycle
        cmp(2'd0, 2'b01, 0, 0, 0, 0, 5'b00001, "R4"); // trapping compare: fcc0 stays 11
        ld_valid = 1; ld_wide = 1; ld_data = 64'h0000_0015_4000_0000;
        op_valid = 1; op_flags = 5'b11111;
        step("R12");                                  // load wins, op dropped
        cmp(2'd2, 2'b10, 0, 0, 0, 0, 5'b00000, "R7"); // field 2 = greater
        cmp(2'd3, 2'b11, 0, 1, 0, 0, 5'b00000, "R8"); // quiet qnan: no invalid
        cmp(2'd1, 2'b11, 1, 1, 0, 0, 5'b00000, "R8"); // signaling qnan: invalid
        cmp(2'd0, 2'b00, 0, 0, 0, 0, 5'b00000, "R7"); // field 0 = equal
        load(64'h0, 0, "R11");                        // clear low word, keep extra fccs
        cmp(2'd0, 2'b11, 0, 1, 0, 1, 5'b00000, "R9"); // wide unordered sets bit 9
        load(64'h0, 0, "R11");
        cmp(2'd0, 2'b01, 0, 0, 0, 1, 5'b00000, "R9"); // wide less: no bit 9
        load(64'h0000_0000_C800_0000, 0, "R10");      // -inf, invalid enabled
        cmp(2'd3, 2'b11, 0, 0, 1, 0, 5'b00000, "R4"); // snan traps, fcc3 kept
        step("R3");
        op(5'b00010, "R5");                           // div0 not enabled: accrues
        load(64'h0000_0000_4000_0000, 1, "R11");      // 64-bit clears extra fccs, zero mode
        step("R10");
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule